// File: doc/BRIEF.md
# Dual-Source Integer Clock-Enable Divider

This block turns one of two incoming tick streams into a slower stream of single-cycle clock-enable pulses. One stream comes from a slow crystal reference. The other is a faster reference produced by an upstream fractional stage. Both arrive as one-cycle enable pulses in the system clock domain. A select bit chooses the stream. Each stream has its own integer ratio field, and each field has its own settling flag.

The output can be held off by a gate bit. It can also be held off by an external wait-for-interrupt input, but only when that input has been allowed to gate the output. Software reaches the settings through a two-word register interface. Each word can be written plainly, or through set, clear and toggle aliases.

Ratio and source changes are never applied in the middle of a division cycle. They are held until the current count ends, so no output period is cut short.

Top module: `dual_src_clkdiv`

## Requirements
- R1: After reset the output is low. The ratio word reads 0x0001_0001, the mode word reads 0x0000_0001, and both settling flags are 0.
- R2: With an active ratio N > 0, one output pulse is produced for every N ticks of the active source. The pulse appears in the cycle after the Nth tick. Ticks of the other source have no effect.
- R3: While the active ratio is 0, no output pulse is produced.
- R4: When a ratio field changes value, its settling flag reads 1 from the next cycle. For the selected, ungated path, the flag clears together with the first output pulse produced under the new ratio.
- R5: A settling flag also clears on a tick of its own source when both of these hold: at least one earlier tick of that source has been counted since the ratio took effect, or since the path stopped being selected; and at that tick the output is gated, or the path is not selected.
- R6: A new ratio loads only when the current count completes, so the period in progress keeps its old length.
- R7: The gate bit (mode bit 1) blocks output pulses while it is 1. Output resumes once it is 0.
- R8: When the wait-gating enable (mode bit 2) is 1 and wfi_in is high, no pulse is produced. With the enable at 0, wfi_in has no effect.
- R9: wr_addr[2] picks the word (0 ratio, 1 mode). wr_addr[1:0] picks the write form: 0 plain, 1 set, 2 clear, 3 toggle. Set, clear and toggle touch only the bits that are 1 in wr_data.
- R10: Mode bit 0 selects the crystal stream when 1 and the fast stream when 0. A change of this bit takes effect at the end of the current count, and it sets the settling flag of the newly selected path.
- R11: The crystal ratio occupies ratio-word bits [7:0] and the fast ratio occupies bits [21:16]. The settling flags read at mode bits 8 (crystal) and 9 (fast) and are read-only: writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | Crystal reference enable pulse |
| fast_tick | input | 1 | Fast reference enable pulse |
| wfi_in | input | 1 | Wait-for-interrupt indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word select and write form |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read word select (0 ratio, 1 mode) |
| rd_data | output | 32 | Selected word, combinational |
| clk_en_out | output | 1 | Divided clock-enable pulse |

## Verification
The assertions assume that the tick inputs are single-cycle pulses synchronous to clk, and that the register inputs are stable across each active edge. They draw no conclusion about a source that never ticks. The bench raises every tick for exactly one cycle and lowers it before the next edge. It drives writes and wfi_in only between edges, and it never leaves a selected source idle while it waits for a load. Because of this, every ratio and source change reaches its count boundary inside the test.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        WR_PLAIN = 2'd0,
        WR_SET   = 2'd1,
        WR_CLR   = 2'd2,
        WR_FLIP  = 2'd3
    } wr_form_e;

    localparam int unsigned MODE_BYP_BIT  = 0;
    localparam int unsigned MODE_GATE_BIT = 1;
    localparam int unsigned MODE_WFI_BIT  = 2;
    localparam int unsigned MODE_BSYX_BIT = 8;
    localparam int unsigned MODE_BSYF_BIT = 9;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int unsigned XTAL_W   = 8,
    parameter int unsigned FAST_W   = 6,
    parameter int unsigned FAST_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic              busy_xtal,
    input  logic              busy_fast,
    output logic [WORD_W-1:0] rd_data,
    output logic [XTAL_W-1:0] xtal_div,
    output logic [FAST_W-1:0] fast_div,
    output logic              bypass,
    output logic              gate,
    output logic              wfi_en,
    output logic              xtal_touch,
    output logic              fast_touch
);
    typedef struct packed {
        logic [XTAL_W-1:0] xdiv;
        logic [FAST_W-1:0] fdiv;
        logic              byp;
        logic              gate;
        logic              wfi;
    } regs_t;

    regs_t r_d, r_q;
    logic [WORD_W-1:0] ratio_word, mode_word, cur_word, nxt_word;
    logic              nxt_unused;

    always_comb begin
        ratio_word = '0;
        ratio_word[XTAL_W-1:0]       = r_q.xdiv;
        ratio_word[FAST_LSB +: FAST_W] = r_q.fdiv;
        mode_word = '0;
        mode_word[MODE_BYP_BIT]  = r_q.byp;
        mode_word[MODE_GATE_BIT] = r_q.gate;
        mode_word[MODE_WFI_BIT]  = r_q.wfi;
        cur_word = wr_addr[2] ? mode_word : ratio_word;
        case (wr_form_e'(wr_addr[1:0]))
            WR_SET:  nxt_word = cur_word | wr_data;
            WR_CLR:  nxt_word = cur_word & ~wr_data;
            WR_FLIP: nxt_word = cur_word ^ wr_data;
            default: nxt_word = wr_data;
        endcase
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr[2]) begin
                r_d.byp  = nxt_word[MODE_BYP_BIT];
                r_d.gate = nxt_word[MODE_GATE_BIT];
                r_d.wfi  = nxt_word[MODE_WFI_BIT];
            end else begin
                r_d.xdiv = nxt_word[XTAL_W-1:0];
                r_d.fdiv = nxt_word[FAST_LSB +: FAST_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.xdiv <= XTAL_W'(1);
            r_q.fdiv <= FAST_W'(1);
            r_q.byp  <= 1'b1;
            r_q.gate <= 1'b0;
            r_q.wfi  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign nxt_unused = ^nxt_word;
    assign xtal_touch = (r_d.xdiv != r_q.xdiv) || (r_d.byp && !r_q.byp);
    assign fast_touch = (r_d.fdiv != r_q.fdiv) || (!r_d.byp && r_q.byp);
    assign xtal_div   = r_q.xdiv;
    assign fast_div   = r_q.fdiv;
    assign bypass     = r_q.byp;
    assign gate       = r_q.gate;
    assign wfi_en     = r_q.wfi;

    always_comb begin
        rd_data = ratio_word;
        if (rd_sel) begin
            rd_data = mode_word;
            rd_data[MODE_BSYX_BIT] = busy_xtal;
            rd_data[MODE_BSYF_BIT] = busy_fast;
        end
    end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick,
    input  logic             fast_tick,
    input  logic             bypass,
    input  logic [DIV_W-1:0] xtal_div,
    input  logic [DIV_W-1:0] fast_div,
    input  logic             gated,
    output logic             out_pulse,
    output logic             out_next,
    output logic             boundary,
    output logic             src_is_xtal
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        logic             xsrc;
        logic             out;
    } core_t;

    core_t c_d, c_q;
    logic  src_tick;

    always_comb begin
        src_tick = c_q.xsrc ? xtal_tick : fast_tick;
        boundary = src_tick &&
                   (({1'b0, c_q.cnt} + 1'b1) >= {1'b0, c_q.ratio});
        c_d      = c_q;
        c_d.out  = boundary && (c_q.ratio != '0) && !gated;
        if (src_tick) begin
            if (boundary) begin
                c_d.cnt   = '0;
                c_d.xsrc  = bypass;
                c_d.ratio = bypass ? xtal_div : fast_div;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt   <= '0;
            c_q.ratio <= DIV_W'(1);
            c_q.xsrc  <= 1'b1;
            c_q.out   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_pulse   = c_q.out;
    assign out_next    = c_d.out;
    assign src_is_xtal = c_q.xsrc;

    assert_gate_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.out |-> $past(!gated));
    assert_zero_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.out |-> ($past(c_q.ratio) != '0));
    assert_switch_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.xsrc) |-> $past(boundary));
    assert_ratio_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.ratio) |-> $past(boundary));
endmodule

// File: rtl/clkdiv_busy.sv
module clkdiv_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    input  logic src_tick,
    input  logic selected,
    input  logic load_evt,
    input  logic out_evt,
    input  logic gated,
    output logic busy
);
    typedef struct packed {
        logic busy;
        logic loaded;
        logic seen;
    } busy_t;

    busy_t b_d, b_q;
    logic  counted;

    always_comb begin
        counted = src_tick && (b_q.loaded || !selected);
        b_d     = b_q;
        if (b_q.busy) begin
            if (b_q.loaded && out_evt)
                b_d.busy = 1'b0;
            else if (counted && b_q.seen && (gated || !selected))
                b_d.busy = 1'b0;
            if (counted)
                b_d.seen = 1'b1;
            if (load_evt && !b_q.loaded) begin
                b_d.loaded = 1'b1;
                b_d.seen   = 1'b0;
            end
        end
        if (!b_d.busy) begin
            b_d.loaded = 1'b0;
            b_d.seen   = 1'b0;
        end
        if (touch) begin
            b_d.busy   = 1'b1;
            b_d.loaded = 1'b0;
            b_d.seen   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign busy = b_q.busy;

    assert_busy_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_q.busy) |-> $past(src_tick || out_evt));
endmodule

// File: rtl/dual_src_clkdiv.sv
module dual_src_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int unsigned XTAL_W   = 8,
    parameter int unsigned FAST_W   = 6,
    parameter int unsigned FAST_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              fast_tick,
    input  logic              wfi_in,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              clk_en_out
);
    localparam int unsigned DIV_W = (XTAL_W > FAST_W) ? XTAL_W : FAST_W;
    localparam int unsigned NPATH = 2;

    logic [XTAL_W-1:0] xtal_div;
    logic [FAST_W-1:0] fast_div;
    logic bypass, gate, wfi_en, gated, boundary, out_next, src_is_xtal;
    logic [NPATH-1:0] touch, tick, sel, load, oevt, busy;

    clkdiv_regs #(.XTAL_W(XTAL_W), .FAST_W(FAST_W), .FAST_LSB(FAST_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_sel(rd_sel), .busy_xtal(busy[1]),
        .busy_fast(busy[0]), .rd_data(rd_data), .xtal_div(xtal_div),
        .fast_div(fast_div), .bypass(bypass), .gate(gate), .wfi_en(wfi_en),
        .xtal_touch(touch[1]), .fast_touch(touch[0])
    );

    assign gated = gate || (wfi_en && wfi_in);

    clkdiv_core #(.DIV_W(DIV_W)) u_core (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .fast_tick(fast_tick),
        .bypass(bypass), .xtal_div(DIV_W'(xtal_div)), .fast_div(DIV_W'(fast_div)),
        .gated(gated), .out_pulse(clk_en_out), .out_next(out_next),
        .boundary(boundary), .src_is_xtal(src_is_xtal)
    );

    assign tick = {xtal_tick, fast_tick};
    assign sel  = {bypass, !bypass};
    assign load = {boundary && bypass, boundary && !bypass};
    assign oevt = {out_next && src_is_xtal, out_next && !src_is_xtal};

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        clkdiv_busy u_busy (
            .clk(clk), .rst_n(rst_n), .touch(touch[p]), .src_tick(tick[p]),
            .selected(sel[p]), .load_evt(load[p]), .out_evt(oevt[p]),
            .gated(gated), .busy(busy[p])
        );
    end

    assert_busy_on_xchange_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xtal_div) |-> busy[1]);
    assert_busy_on_fchange_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fast_div) |-> busy[0]);
    assert_wfi_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> !$past(wfi_en && wfi_in));
endmodule

// File: tb/dual_src_clkdiv_test.sv
`timescale 1ns/1ps
module dual_src_clkdiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0, fast_tick = 1'b0, wfi_in = 1'b0;
    logic        wr_en = 1'b0, rd_sel = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_en_out;
    int checks = 0, failures = 0;

    dual_src_clkdiv uut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .fast_tick(fast_tick),
        .wfi_in(wfi_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_en_out(clk_en_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(input logic s, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_sel = s; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic step(input logic x, input logic f, input logic exp, input string tag);
        @(negedge clk); xtal_tick = x; fast_tick = f;
        @(posedge clk); #1; xtal_tick = 1'b0; fast_tick = 1'b0;
        @(negedge clk);
        chk(tag, {31'd0, clk_en_out}, {31'd0, exp});
    endtask

    task automatic t_reset;
        chk("R1 out", {31'd0, clk_en_out}, 32'd0);
        rd(1'b0, 32'h0001_0001, "R1 ratio word");
        rd(1'b1, 32'h0000_0001, "R1 mode word");
    endtask

    task automatic t_divide;
        step(1, 0, 1, "R2 div1 a");
        step(1, 0, 1, "R2 div1 b");
        step(0, 1, 0, "R2 other source ignored");
        wr(3'd0, 32'h0001_0003);
        rd(1'b1, 32'h0000_0101, "R4 busy set");
        step(1, 0, 1, "R6 old ratio finishes");
        step(1, 0, 0, "R2 div3 a");
        rd(1'b1, 32'h0000_0101, "R4 busy held");
        step(1, 0, 0, "R2 div3 b");
        step(1, 0, 1, "R2 div3 c");
        rd(1'b1, 32'h0000_0001, "R4 busy cleared on pulse");
    endtask

    task automatic t_midcount;
        step(1, 0, 0, "R6 count 1");
        wr(3'd0, 32'h0001_0002);
        step(1, 0, 0, "R6 count 2");
        step(1, 0, 1, "R6 full old period");
        step(1, 0, 0, "R6 new 1");
        step(1, 0, 1, "R6 new period 2");
    endtask

    task automatic t_zero_and_gate;
        wr(3'd0, 32'h0001_0000);
        step(1, 0, 0, "R6 zero pending");
        step(1, 0, 1, "R6 zero loads");
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R3 zero ratio silent");
        rd(1'b1, 32'h0000_0101, "R3 busy stays ungated");
        wr(3'd5, 32'h0000_0002);
        step(1, 0, 0, "R7 gated");
        rd(1'b1, 32'h0000_0003, "R5 gated busy clears");
        wr(3'd0, 32'h0001_0001);
        step(1, 0, 0, "R7 gated load");
        step(1, 0, 0, "R7 gated no pulse");
        rd(1'b1, 32'h0000_0103, "R5 one tick not enough");
        step(1, 0, 0, "R7 gated no pulse b");
        rd(1'b1, 32'h0000_0003, "R5 second tick clears");
        wr(3'd6, 32'h0000_0002);
        step(1, 0, 1, "R7 ungated resumes");
    endtask

    task automatic t_bypass;
        wr(3'd0, 32'h0002_0001);
        rd(1'b1, 32'h0000_0201, "R4 fast busy set");
        step(0, 1, 0, "R5 unselected tick a");
        step(0, 1, 0, "R5 unselected tick b");
        rd(1'b1, 32'h0000_0001, "R5 unselected clears");
        wr(3'd7, 32'h0000_0001);
        rd(1'b1, 32'h0000_0200, "R10 toggle and busy");
        step(0, 1, 0, "R10 switch waits");
        step(1, 0, 1, "R10 crystal boundary");
        step(0, 1, 0, "R10 fast div2 a");
        step(0, 1, 1, "R10 fast div2 b");
        rd(1'b1, 32'h0000_0000, "R10 busy clears");
        step(1, 0, 0, "R2 crystal ignored");
    endtask

    task automatic t_wfi;
        wr(3'd5, 32'h0000_0004);
        @(negedge clk); wfi_in = 1'b1;
        step(0, 1, 0, "R8 wfi a");
        step(0, 1, 0, "R8 wfi blocks");
        @(negedge clk); wfi_in = 1'b0;
        step(0, 1, 0, "R8 after a");
        step(0, 1, 1, "R8 after b");
        wr(3'd6, 32'h0000_0004);
        @(negedge clk); wfi_in = 1'b1;
        step(0, 1, 0, "R8 disabled a");
        step(0, 1, 1, "R8 disabled no effect");
        @(negedge clk); wfi_in = 1'b0;
    endtask

    task automatic t_alias;
        wr(3'd1, 32'h0000_0004);
        rd(1'b0, 32'h0002_0005, "R9 set alias");
        wr(3'd2, 32'h0000_0001);
        rd(1'b0, 32'h0002_0004, "R9 clear alias");
        wr(3'd3, 32'h0003_0000);
        rd(1'b0, 32'h0001_0004, "R11 toggle fast field");
        wr(3'd6, 32'h0000_0300);
        rd(1'b1, 32'h0000_0300, "R11 busy read-only");
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_midcount();
        t_zero_and_gate();
        t_bypass();
        t_wfi();
        t_alias();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule